// File: doc/BRIEF.md
# Comma-Seeking Barrel-Shift Word Aligner

This block sits right after a deserializer and runs in the recovered receive clock domain. Each cycle it may receive one 20-bit parallel word cut from an 8b/10b-style DC-balanced line stream. Nothing in that stream marks where a word starts. The block searches every possible bit offset for a comma code group and settles on one shift. It then produces realigned 20-bit words. It also reports the chosen shift as a 5-bit bit-slide value.

That bit-slide value is the reason the block exists. The alignment delay is known to one bit period, which is 800 ps at a 1.25 Gbps line rate. A downstream delay-measurement circuit adds bit-slide × unit interval to its coarse start-stop count. The result is a propagation delay with bit resolution.

The input side carries only a valid strobe. A deserializer cannot pause the line, so there is no back-pressure: the block accepts every word marked valid. The output side is a valid-only stream with a fixed delay, and the consumer must take each word in the cycle it appears. The lock flag and the bit-slide value are plain status outputs.

Top module: `comma_word_aligner`

## Requirements
- R1: Bit 0 of each input word is the earliest received bit. The search window is {current word, previous valid word}, 40 bits, with the previous word in bits 19:0. A comma at offset k (0..19) occupies window bits k..k+9. It matches either form, listed earliest bit first: 0011111010 (10'b0101111100) or its complement 1100000101 (10'b1010000011).
- R2: When commas match at several offsets in one window, the lowest offset is the one taken.
- R3: While unlocked, a comma window whose offset equals the candidate offset raises the candidate count. A comma at any other offset makes that offset the new candidate with count 1. When the count reaches 3, lock is declared at that offset. Windows without a comma leave the count unchanged.
- R4: While unlocked, `lock` is 0 and `out_valid` stays 0.
- R5: While locked, a comma at the locked offset clears the mismatch count. Four consecutive commas at other offsets drop lock. The fourth comma's offset then becomes the candidate with count 1.
- R6: While locked, a word accepted on one rising edge produces `out_valid`=1 on the next edge. `out_data` is then window bits s..s+19, where s is the bit-slide value.
- R7: `out_slide` holds the offset of the most recent lock, always in 0..19, and keeps it unchanged while locked.
- R8: A cycle with `in_valid` low captures nothing, yields no output word on the following edge, and leaves the lock state unchanged.
- R9: After reset, `lock`, `out_valid` and `out_slide` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 20 | Deserialized word, bit 0 earliest |
| out_valid | output | 1 | Aligned word present this cycle |
| out_data | output | 20 | Aligned word, bit 0 earliest |
| out_slide | output | 5 | Locked bit-slide offset |
| lock | output | 1 | Alignment locked |

## Verification
The bench uses the default build: 20-bit words, 10-bit symbols, 3 hits to lock and 4 foreign commas to unlock. With 20-bit words the extreme offsets 0 and 19 can be reached. Offset 19 places a comma across the word boundary, and pairs of commas 10 bits apart exercise the lowest-offset rule. The small lock and loss thresholds let the bench drive every lock, hold, drop and relock path many times with a few hundred words. Comma-free filler is random but run-limited, so the only matches are the commas the bench places.

// File: rtl/wa_pkg.sv
package wa_pkg;
  // Comma forms, earliest received bit in bit 0
  localparam logic [9:0] COMMA_RD_NEG = 10'b0101111100;
  localparam logic [9:0] COMMA_RD_POS = 10'b1010000011;
endpackage

// File: rtl/wa_comma_scan.sv
module wa_comma_scan #(
  parameter int WORD_W = 20,
  parameter int SYM_W = 10,
  parameter int SLIDE_W = 5,
  parameter logic [SYM_W-1:0] PAT_A = wa_pkg::COMMA_RD_NEG,
  parameter logic [SYM_W-1:0] PAT_B = wa_pkg::COMMA_RD_POS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*WORD_W-1:0]   win,
  output logic                  hit,
  output logic [SLIDE_W-1:0]    hit_off
);
  logic [WORD_W-1:0] match;

  for (genvar k = 0; k < WORD_W; k++) begin : g_off
    assign match[k] = (win[k +: SYM_W] == PAT_A) || (win[k +: SYM_W] == PAT_B);
  end

  always_comb begin
    hit_off = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (match[i]) hit_off = SLIDE_W'(i);
    end
  end

  assign hit = |match;

  // R2: the chosen offset matches and nothing below it does
  assert_lowest_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[hit_off] && ((match & ((WORD_W'(1) << hit_off) - WORD_W'(1))) == '0)));
endmodule

// File: rtl/wa_lock_ctrl.sv
module wa_lock_ctrl #(
  parameter int SLIDE_W = 5,
  parameter int LOCK_HITS = 3,
  parameter int LOSS_HITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               hit,
  input  logic [SLIDE_W-1:0] hit_off,
  output logic               locked,
  output logic [SLIDE_W-1:0] slide
);
  localparam int CNT_W = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(LOSS_HITS + 1);

  logic [SLIDE_W-1:0] cand_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [MISS_W-1:0]  miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      slide  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
      miss_q <= '0;
    end else if (step && hit) begin
      if (!locked) begin
        if (cnt_q != '0 && hit_off == cand_q) begin
          if (cnt_q == CNT_W'(LOCK_HITS - 1)) begin
            locked <= 1'b1;
            slide  <= hit_off;
            cnt_q  <= '0;
            miss_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cand_q <= hit_off;
          cnt_q  <= CNT_W'(1);
        end
      end else if (hit_off == slide) begin
        miss_q <= '0;
      end else if (miss_q == MISS_W'(LOSS_HITS - 1)) begin
        locked <= 1'b0;
        cand_q <= hit_off;
        cnt_q  <= CNT_W'(1);
        miss_q <= '0;
      end else begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end

  // R3: lock rises only on a comma at the new slide offset
  assert_lock_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(step) && $past(hit) && $past(hit_off) == slide));
  // R3: candidate count never exceeds its threshold
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LOCK_HITS));
  // R5: lock drops only on a comma at a foreign offset
  assert_drop_foreign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(step) && $past(hit) && $past(hit_off) != $past(slide)));
  // R7: slide is frozen while lock holds
  assert_slide_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(slide));
endmodule

// File: rtl/wa_shift_out.sv
module wa_shift_out #(
  parameter int WORD_W = 20,
  parameter int SLIDE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*WORD_W-1:0] win,
  input  logic                win_valid,
  input  logic                locked,
  input  logic [SLIDE_W-1:0]  slide,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= win_valid && locked;
      if (win_valid && locked) out_data <= WORD_W'(win >> slide);
    end
  end

  // R4: no output word unless lock held on the previous edge
  assert_valid_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(locked));
  // R8: an idle window yields no output on the next edge
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> !out_valid);
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int WORD_W = 20,
  parameter int SYM_W = 10,
  parameter int LOCK_HITS = 3,
  parameter int LOSS_HITS = 4,
  parameter logic [SYM_W-1:0] PAT_A = wa_pkg::COMMA_RD_NEG,
  parameter logic [SYM_W-1:0] PAT_B = wa_pkg::COMMA_RD_POS,
  localparam int SLIDE_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_data,
  output logic [SLIDE_W-1:0] out_slide,
  output logic               lock
);
  logic [WORD_W-1:0]   cur_q, prev_q;
  logic                win_valid;
  logic [2*WORD_W-1:0] win;
  logic                hit;
  logic [SLIDE_W-1:0]  hit_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q     <= '0;
      prev_q    <= '0;
      win_valid <= 1'b0;
    end else begin
      win_valid <= in_valid;
      if (in_valid) begin
        cur_q  <= in_data;
        prev_q <= cur_q;
      end
    end
  end

  assign win = {cur_q, prev_q};

  wa_comma_scan #(.WORD_W(WORD_W), .SYM_W(SYM_W), .SLIDE_W(SLIDE_W),
                  .PAT_A(PAT_A), .PAT_B(PAT_B)) u_scan (
    .clk(clk), .rst_n(rst_n), .win(win), .hit(hit), .hit_off(hit_off));

  wa_lock_ctrl #(.SLIDE_W(SLIDE_W), .LOCK_HITS(LOCK_HITS), .LOSS_HITS(LOSS_HITS)) u_lock (
    .clk(clk), .rst_n(rst_n), .step(win_valid), .hit(hit), .hit_off(hit_off),
    .locked(lock), .slide(out_slide));

  wa_shift_out #(.WORD_W(WORD_W), .SLIDE_W(SLIDE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .win(win), .win_valid(win_valid), .locked(lock),
    .slide(out_slide), .out_valid(out_valid), .out_data(out_data));

  // R7: reported slide is a legal offset
  assert_slide_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_slide < SLIDE_W'(WORD_W));
  // R8: an idle cycle leaves lock untouched on the next edge
  assert_idle_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> $stable(lock));
endmodule

// File: tb/comma_word_aligner_tb.sv
module comma_word_aligner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int LOCK_N = 3;
  localparam int LOSS_N = 4;
  localparam int NBITS = 8192;
  localparam logic [9:0] C_NEG = 10'b0101111100;
  localparam logic [9:0] C_POS = 10'b1010000011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;
  logic [4:0] out_slide;
  logic lock;

  comma_word_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_slide(out_slide), .lock(lock));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails = 0;
  bit sbits [0:NBITS-1];
  int cm [0:399];
  int wn = 0;
  logic [24:0] exp_q [$];
  bit m_lock = 0;
  int m_slide = 0, m_cand = 0, m_cnt = 0, m_miss = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Model of R3/R5 driven by comma offsets
  task automatic model_step(input int off);
    if (!m_lock) begin
      if (m_cnt != 0 && off == m_cand) begin
        m_cnt++;
        if (m_cnt == LOCK_N) begin m_lock = 1; m_slide = off; m_cnt = 0; m_miss = 0; end
      end else begin
        m_cand = off; m_cnt = 1;
      end
    end else if (off == m_slide) begin
      m_miss = 0;
    end else begin
      m_miss++;
      if (m_miss == LOSS_N) begin m_lock = 0; m_cand = off; m_cnt = 1; m_miss = 0; end
    end
  endtask

  task automatic place(input int p, input bit pos_form);
    for (int j = 0; j < 10; j++) sbits[p + j] = pos_form ? C_POS[j] : C_NEG[j];
  endtask

  // Send word wn; ka/kb comma offsets in it (-1 none), ka the lower
  task automatic send(input int ka, input int kb, input bit pos_form);
    logic [W-1:0] w;
    logic [W-1:0] e;
    if (ka >= 0) place(W*wn + ka, pos_form);
    if (kb >= 0) place(W*wn + kb, pos_form);
    cm[wn] = ka;
    for (int i = 0; i < W; i++) w[i] = sbits[W*wn + i];
    @(negedge clk);
    in_valid = 1'b1;
    in_data = w;
    if (wn >= 1) begin
      if (m_lock) begin
        for (int i = 0; i < W; i++) e[i] = sbits[W*(wn-1) + m_slide + i];
        exp_q.push_back({5'(m_slide), e});
      end
      if (cm[wn-1] >= 0) model_step(cm[wn-1]);
    end
    wn++;
  endtask

  task automatic idle(input int c);
    repeat (c) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check_state(input string req);
    idle(2);
    check({req, " lock"}, 32'(lock), 32'(m_lock));
    if (m_lock) check({req, " slide"}, 32'(out_slide), 32'(m_slide));
  endtask

  // Scoreboard monitor (R4, R6)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected out_valid", 32'(out_valid), 32'h0);
      end else begin
        logic [24:0] x;
        x = exp_q.pop_front();
        check("R6 out_data", 32'(out_data), 32'(x[19:0]));
        check("R7 out_slide with word", 32'(out_slide), 32'(x[24:20]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    // Run-limited random filler: never three equal bits, so no spurious comma
    for (int i = 0; i < NBITS; i++) begin
      if (i >= 2 && sbits[i-1] == sbits[i-2]) sbits[i] = ~sbits[i-1];
      else sbits[i] = 1'($urandom % 2);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset lock", 32'(lock), 32'h0);
    check("R9 reset out_valid", 32'(out_valid), 32'h0);
    check("R9 reset out_slide", 32'(out_slide), 32'h0);

    // R3/R4: two commas at 7 are not enough
    send(-1, -1, 0); send(-1, -1, 0);
    send(7, -1, 0); send(7, -1, 0); send(-1, -1, 0);
    check_state("R3 two hits no lock");
    check("R4 no output unlocked", 32'(out_valid), 32'h0);
    // R8: gap above did not break the run; third comma locks
    send(7, -1, 0); send(-1, -1, 0);
    check_state("R3 lock at 7");
    check("R3 locked", 32'(lock), 32'h1);
    for (int i = 0; i < 6; i++) send((i % 2) ? 7 : -1, -1, 0);
    // R6 latency and R8 idle quiet
    send(-1, -1, 0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); check("R6 latency one edge", 32'(out_valid), 32'h1);
    @(negedge clk); check("R8 idle no output", 32'(out_valid), 32'h0);

    // R5: three foreign, one matching, three foreign keeps lock
    for (int i = 0; i < 3; i++) send(13, -1, 0);
    send(7, -1, 0);
    for (int i = 0; i < 3; i++) send(13, -1, 0);
    send(-1, -1, 0);
    check_state("R5 hold lock");
    check("R5 still locked", 32'(lock), 32'h1);
    send(13, -1, 0); send(-1, -1, 0);
    check_state("R5 drop lock");
    check("R5 unlocked", 32'(lock), 32'h0);
    send(13, -1, 0); send(13, -1, 0); send(-1, -1, 0);
    check_state("R5 relock at 13");

    // R1/R7: positive-disparity comma at offset 19 (crosses word edge)
    for (int i = 0; i < 6; i++) send(19, -1, 1);
    send(-1, -1, 0);
    check_state("R1 relock at 19");
    check("R7 slide 19", 32'(out_slide), 32'd19);

    // R1: offset 0, negative form
    for (int i = 0; i < 6; i++) send(0, -1, 0);
    send(-1, -1, 0);
    check_state("R1 relock at 0");
    check("R7 slide 0", 32'(out_slide), 32'd0);

    // R2: commas at 3 and 13 together, lowest wins
    for (int i = 0; i < 6; i++) send(3, 13, 0);
    send(-1, -1, 1);
    check_state("R2 lowest offset");
    check("R2 slide 3", 32'(out_slide), 32'd3);

    // R3: candidate restart while unlocked
    for (int i = 0; i < 4; i++) send(11, -1, 0);
    send(5, -1, 0); send(11, -1, 0); send(11, -1, 0); send(-1, -1, 0);
    check_state("R3 restart no lock");
    check("R3 restart unlocked", 32'(lock), 32'h0);
    send(11, -1, 1); send(-1, -1, 0);
    check_state("R3 lock at 11");
    check("R3 slide 11", 32'(out_slide), 32'd11);

    // R8: gapped traffic while locked
    for (int i = 0; i < 8; i++) begin
      send((i % 3 == 0) ? 11 : -1, -1, 0);
      idle(i % 3);
    end
    send(-1, -1, 0);
    check_state("R8 gaps keep lock");
    idle(3);
    check("R6 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    report();
  end
endmodule